// File: doc/BRIEF.md
# Churning Address Displacement Unit

This block sits on the request path between a processor and its memory and hides where instructions and data really live. It keeps two secret displacements, one for instruction fetches and one for data accesses, and applies the one that matches each outgoing request. A write has the displacement added to its address and a read has it subtracted. All arithmetic wraps around the address space.

A churn controller replaces both displacements and a cipher key with fresh pseudo-random values. This happens on a fixed period counted in clock cycles, and it also happens at once when the attack-detected input is raised. Each value comes from its own free-running 32-bit maximal-length LFSR. The low four bits of each displacement are cleared so that word alignment is kept. A one-cycle churn pulse tells the rest of the system that new secrets are in force. The block does not move or re-encrypt memory contents that already exist, and it does not contain the cipher itself.

Top module: `churn_addr_unit`

## Requirements
- R1: A write request (`req_write`=1) gives `out_addr` = `req_addr` + the selected displacement.
- R2: A read request (`req_write`=0) gives `out_addr` = `req_addr` − the selected displacement.
- R3: `req_code`=1 selects the instruction displacement and `req_code`=0 selects the data displacement. The two are drawn from separate generators and differ after a churn.
- R4: Bits [3:0] of both displacements are always zero.
- R5: Address arithmetic wraps modulo 2^ADDR_W, with no fault or saturation.
- R6: Without an attack, a churn happens every PERIOD clock edges. The first churn happens on the PERIOD-th edge after reset. `churn_pulse` is high for the one cycle that follows each churn edge.
- R7: When `attack` is high at a clock edge, a churn happens on that edge. The period count then restarts from zero.
- R8: Each churn loads a new nonzero `key_out` that differs from the previous key. Between churns the key holds still.
- R9: A request sampled on a churn edge is translated with the displacements from before that churn.
- R10: `out_valid` and `out_addr` are registered: a request at edge k appears after edge k. `out_valid` follows `req_valid` with one cycle of delay.
- R11: After reset, `key_out`=0, `churn_pulse`=0 and both displacements are zero, so translated addresses equal raw addresses until the first churn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Address as seen by the program |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = instruction reference, 0 = data reference |
| attack | input | 1 | Attack detected; forces an immediate churn |
| out_valid | output | 1 | Translated address is valid |
| out_addr | output | ADDR_W | Translated (physical) address |
| key_out | output | KEY_W | Current cipher key |
| churn_pulse | output | 1 | One-cycle pulse after each churn |

## Verification
The bench builds the block with PERIOD=40 and a 32-bit address and key. With these values many timer churns and attack-forced churns fit into a few hundred cycles, and the period restart after an attack can be seen clearly. The reference model learns each secret displacement from the first request of its class after a churn. It then predicts every later address of that class. A quarter of the addresses lie near the top of the space, which exercises wrap-around under any displacement.

// File: rtl/churn_pkg.sv
package churn_pkg;
  localparam int LFSR_W = 32;
  // x^32 + x^22 + x^2 + x + 1, Galois form shifting right
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
  localparam int ALIGN_BITS = 4;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/churn_lfsr.sv
module churn_lfsr
  import churn_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'h1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= lfsr_step(state);
  end
endmodule

// File: rtl/churn_timer.sv
module churn_timer #(
  parameter int PERIOD = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic attack,
  output logic fire
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign fire = attack || (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (fire) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/churn_xlate.sv
module churn_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              code,
  input  logic [ADDR_W-1:0] disp_code,
  input  logic [ADDR_W-1:0] disp_data,
  output logic [ADDR_W-1:0] xaddr
);
  logic [ADDR_W-1:0] sel;
  always_comb begin
    sel   = code ? disp_code : disp_data;
    xaddr = write ? (addr + sel) : (addr - sel);
  end
endmodule

// File: rtl/churn_addr_unit.sv
module churn_addr_unit
  import churn_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                KEY_W     = 32,
  parameter int                PERIOD    = 12_500_000,
  parameter logic [LFSR_W-1:0] SEED_CODE = 32'hA5C3_1E07,
  parameter logic [LFSR_W-1:0] SEED_DATA = 32'h3B91_F46D,
  parameter logic [LFSR_W-1:0] SEED_KEY  = 32'h6E2D_8C59
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_code,
  input  logic              attack,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [KEY_W-1:0]  key_out,
  output logic              churn_pulse
);
  localparam int NGEN = 3;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [LFSR_W-1:0] rnd [NGEN];
  logic [ADDR_W-1:0] disp_code, disp_data, xaddr;
  logic              fire;

  for (genvar g = 0; g < NGEN; g++) begin : g_rng
    localparam logic [LFSR_W-1:0] SEED = (g == 0) ? SEED_CODE :
                                         (g == 1) ? SEED_DATA : SEED_KEY;
    churn_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .state(rnd[g]));
  end

  churn_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .attack(attack), .fire(fire)
  );

  churn_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .addr(req_addr), .write(req_write), .code(req_code),
    .disp_code(disp_code), .disp_data(disp_data), .xaddr(xaddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_code   <= '0;
      disp_data   <= '0;
      key_out     <= '0;
      churn_pulse <= 1'b0;
    end else begin
      churn_pulse <= fire;
      if (fire) begin
        disp_code <= rnd[0][ADDR_W-1:0] & ALIGN_MASK;
        disp_data <= rnd[1][ADDR_W-1:0] & ALIGN_MASK;
        key_out   <= rnd[2][KEY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) out_addr <= xaddr;
    end
  end
endmodule

// File: rtl/churn_addr_chk.sv
module churn_addr_chk #(
  parameter int ADDR_W = 32,
  parameter int KEY_W  = 32,
  parameter int PERIOD = 12_500_000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              attack,
  input logic              out_valid,
  input logic              churn_pulse,
  input logic [KEY_W-1:0]  key_out,
  input logic [ADDR_W-1:0] disp_code,
  input logic [ADDR_W-1:0] disp_data
);
  int unsigned gap;
  always_ff @(posedge clk) begin
    if (rst || churn_pulse) gap <= 0;
    else                    gap <= gap + 1;
  end

  AST_DISP_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (disp_code[3:0] == 4'h0) && (disp_data[3:0] == 4'h0)); // R4
  AST_ATTACK_CHURN: assert property (@(posedge clk) disable iff (rst)
    attack |=> churn_pulse); // R7
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !churn_pulse |-> $stable(key_out)); // R8
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R10
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid); // R10
  AST_PERIOD_GAP: assert property (@(posedge clk) disable iff (rst)
    gap <= PERIOD); // R6
endmodule

bind churn_addr_unit churn_addr_chk #(
  .ADDR_W(ADDR_W), .KEY_W(KEY_W), .PERIOD(PERIOD)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .attack(attack),
  .out_valid(out_valid), .churn_pulse(churn_pulse), .key_out(key_out),
  .disp_code(disp_code), .disp_data(disp_data)
);

// File: tb/churn_addr_unit_bench.sv
module churn_addr_unit_bench;
  localparam int AW = 32;
  localparam int KW = 32;
  localparam int P  = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_code = 1'b0, attack = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          out_valid, churn_pulse;
  logic [AW-1:0] out_addr;
  logic [KW-1:0] key_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  churn_addr_unit #(.ADDR_W(AW), .KEY_W(KW), .PERIOD(P)) u_churn_addr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_code(req_code), .attack(attack),
    .out_valid(out_valid), .out_addr(out_addr), .key_out(key_out),
    .churn_pulse(churn_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model state
  logic [AW-1:0] m_disp [2];   // index 1 = code, 0 = data
  bit            m_known [2];
  logic [KW-1:0] m_key;
  int            m_cnt;
  bit            p_valid, p_write, p_code, p_attack;
  logic [AW-1:0] p_addr;
  bit            wrap_hits = 0, r9_hits = 0;

  task automatic drive_cycle(input bit v, input bit w, input bit c, input bit atk, input logic [AW-1:0] a);
    bit            fire;
    logic [AW-1:0] exp, d;
    int            ci;
    req_valid = v; req_write = w; req_code = c; attack = atk; req_addr = a;
    p_valid = v; p_write = w; p_code = c; p_attack = atk; p_addr = a;
    @(posedge clk);
    @(negedge clk);
    fire = p_attack || (m_cnt == P - 1);
    m_cnt = fire ? 0 : m_cnt + 1;
    check(out_valid == p_valid, "R10 out_valid", 64'(out_valid), 64'(p_valid));
    if (p_valid) begin
      ci = p_code ? 1 : 0;
      if (m_known[ci]) begin
        exp = p_write ? p_addr + m_disp[ci] : p_addr - m_disp[ci];
        if (p_write && ({1'b0, p_addr} + {1'b0, m_disp[ci]}) > {1'b0, {AW{1'b1}}}) begin
          wrap_hits = 1;
          check(out_addr == exp, "R5 wrap", 64'(out_addr), 64'(exp));
        end else if (fire) begin
          r9_hits = 1;
          check(out_addr == exp, "R9 old values at churn", 64'(out_addr), 64'(exp));
        end else if (p_write)
          check(out_addr == exp, p_code ? "R1 code write" : "R1 data write", 64'(out_addr), 64'(exp));
        else
          check(out_addr == exp, p_code ? "R2 code read" : "R2 data read", 64'(out_addr), 64'(exp));
      end else begin
        d = p_write ? out_addr - p_addr : p_addr - out_addr;
        check(d[3:0] == 4'h0, "R4 displacement alignment", 64'(d), 64'(d & ~32'hF));
        if (m_known[1-ci])
          check(d != m_disp[1-ci], "R3 independent displacements", 64'(d), 64'(m_disp[1-ci]));
        m_disp[ci] = d;
        m_known[ci] = 1;
      end
    end
    check(churn_pulse == fire, fire && p_attack ? "R7 attack churn" : "R6 churn timing",
          64'(churn_pulse), 64'(fire));
    if (fire) begin
      check(key_out != m_key && key_out != '0, "R8 new key", 64'(key_out), 64'(m_key));
      m_key = key_out;
      m_known[0] = 0;
      m_known[1] = 0;
    end else begin
      check(key_out == m_key, "R8 key hold", 64'(key_out), 64'(m_key));
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    if ($urandom_range(0, 3) == 0) return {{(AW-8){1'b1}}, 8'($urandom)};
    return AW'($urandom);
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'd0);
    check(churn_pulse == 1'b0, "R11 reset churn_pulse", 64'(churn_pulse), 64'd0);
    check(key_out == '0, "R11 reset key", 64'(key_out), 64'd0);
    m_disp[0] = '0; m_disp[1] = '0;
    m_known[0] = 1; m_known[1] = 1;
    m_key = '0; m_cnt = 0;

    // R11: identity before the first churn
    drive_cycle(1, 1, 1, 0, 32'h0000_1234);
    check(out_addr == 32'h0000_1234, "R11 identity code write", 64'(out_addr), 64'h1234);
    drive_cycle(1, 0, 0, 0, 32'hFFFF_FFF8);
    check(out_addr == 32'hFFFF_FFF8, "R11 identity data read", 64'(out_addr), 64'hFFFF_FFF8);

    // Mixed traffic across several timer churns
    for (int i = 0; i < 300; i++)
      drive_cycle($urandom_range(0, 4) != 0, $urandom_range(0, 1), $urandom_range(0, 1), 0, pick_addr());

    // Learn both displacements, then attack with a request in flight (R7, R9)
    drive_cycle(1, 0, 1, 0, 32'h1000_0000);
    drive_cycle(1, 0, 0, 0, 32'h2000_0000);
    drive_cycle(1, 1, 1, 1, 32'h3000_0040);
    // Period restarts after attack (R7)
    for (int i = 0; i < 2 * P + 5; i++)
      drive_cycle(1, $urandom_range(0, 1), $urandom_range(0, 1), 0, pick_addr());

    // Random attacks interleaved with traffic
    for (int i = 0; i < 400; i++)
      drive_cycle($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 24) == 0, pick_addr());

    check(wrap_hits == 1, "R5 wrap exercised", 64'(wrap_hits), 64'd1);
    check(r9_hits == 1, "R9 churn-edge request exercised", 64'(r9_hits), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule